// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block lets a clocked system read and write an external asynchronous static RAM of 262,144 sixteen-bit words. On the system side it takes one request at a time through a valid/ready handshake: an 18-bit word address, write data, a read/write flag and a two-bit byte-enable mask. Read results come back on a separate data port, marked by a one-cycle valid pulse.

On the memory side it drives the address, the active-low chip, output and write enables, and one active-low strobe per byte lane. The bidirectional data bus is split into an outgoing value, a drive enable and an incoming value. The length of a read access and of the write pulse are parameters counted in clock cycles. Every access is bracketed by idle cycles with the chip deselected, which keeps the RAM in standby between transactions and leaves the bus turned around before the next one. Requests with an empty byte mask finish without any bus activity.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is asserted, chip enable, output enable, write enable and both byte strobes are high, the data bus is not driven, `req_ready` is 1 and `rdata_valid` is 0.
- R2: Chip enable is high in every cycle in which `req_ready` is high, so the RAM sits in standby whenever no access is in progress.
- R3: A read with a non-empty mask holds chip enable and output enable low and write enable high for exactly `RD_WAIT` cycles. The incoming bus is sampled on the last of these cycles, and `rdata_valid` is high for one cycle, `RD_WAIT + 1` cycles after the accepting clock edge.
- R4: Mask bit 0 selects the lower lane (data bits 7:0, strobe bit 0) and mask bit 1 selects the upper lane (data bits 15:8, strobe bit 1). A strobe is low during an access only for a selected lane. A lane that is not selected reads back as zero in `rdata`, and a write leaves that lane of the RAM unchanged.
- R5: A write holds chip enable low for `WR_WAIT + 2` cycles: one setup cycle with write enable high, `WR_WAIT` cycles with write enable low, and one hold cycle with write enable high. Address, strobes and outgoing data stay constant while chip enable is low, and write enable is low only while chip enable is low and the bus is driven.
- R6: The data bus is driven only during write accesses and never in a cycle in which output enable is low.
- R7: Any two accesses are separated by at least one cycle in which chip enable and output enable are high and the bus is released.
- R8: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low for the whole of an access that touches the bus. After a write it returns high `WR_WAIT + 2` cycles after the accepting edge.
- R9: A request whose mask is all zero leaves chip enable high and `req_ready` high. A write of this kind changes nothing in the RAM. A read of this kind returns all-zero data with `rdata_valid` high in the cycle after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte-lane mask, bit 0 = lower lane |
| rdata | output | 16 | Read data, unselected lanes zero |
| rdata_valid | output | 1 | One-cycle pulse marking `rdata` |
| sram_addr | output | 18 | RAM word address |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_be_n | output | 2 | Byte strobes, active low, bit 0 = lower lane |
| sram_dq_out | output | 16 | Value driven onto the data bus |
| sram_dq_oe | output | 1 | Data bus drive enable |
| sram_dq_in | input | 16 | Value read from the data bus |

## Verification
The assertions assume that requests change only when they are offered, and that the incoming bus value is steady by the sampling edge of a read. The bench meets both. It drives every request on the falling clock edge while `req_ready` is already high, and drops `req_valid` right after the accepting edge. Its RAM model updates the read value on falling edges, and before that it returns a filler pattern, so data sampled too early would be wrong. The bench also mixes reads and writes back to back at a small set of addresses. This covers every change of direction and all four mask values, including the empty one.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_WSETUP = 3'd2,
    ST_WPULSE = 3'd3,
    ST_WHOLD  = 3'd4
  } seq_state_e;

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_en = start | (cnt_q != '0);

  always_comb begin
    if (start) cnt_d = load_val;
    else       cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expire = (cnt_q == '0);

  // R3 / R5: once loaded, the count only moves down until it expires
  a_r3_timer_descends: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !expire) |=> (cnt_q < $past(cnt_q)));

endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int CNT_W   = 3,
  parameter int RD_WAIT = 3,
  parameter int WR_WAIT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_any_lane,
  input  logic             timer_expire,
  output logic             req_ready,
  output logic             accept,
  output logic             capture,
  output logic             timer_start,
  output logic [CNT_W-1:0] timer_load,
  output logic             access_d,
  output logic             ce_n,
  output logic             oe_n,
  output logic             we_n,
  output logic             dq_oe,
  output logic             rdata_valid
);

  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_WAIT - 1);
  localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_WAIT - 1);

  seq_state_e state_q;
  seq_state_e state_d;
  logic ce_n_d, oe_n_d, we_n_d, dq_oe_d;

  assign req_ready = (state_q == ST_IDLE);

  always_comb begin
    state_d     = state_q;
    accept      = 1'b0;
    capture     = 1'b0;
    timer_start = 1'b0;
    timer_load  = RD_LOAD;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          if (!req_any_lane) begin
            capture = !req_write;
          end else if (req_write) begin
            state_d = ST_WSETUP;
          end else begin
            state_d     = ST_READ;
            timer_start = 1'b1;
            timer_load  = RD_LOAD;
          end
        end
      end
      ST_READ: begin
        if (timer_expire) begin
          capture = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_WSETUP: begin
        state_d     = ST_WPULSE;
        timer_start = 1'b1;
        timer_load  = WR_LOAD;
      end
      ST_WPULSE: begin
        if (timer_expire) state_d = ST_WHOLD;
      end
      ST_WHOLD: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Pin values for the next cycle, decoded from the next state
  always_comb begin
    access_d = (state_d != ST_IDLE);
    ce_n_d   = (state_d == ST_IDLE);
    oe_n_d   = (state_d != ST_READ);
    we_n_d   = (state_d != ST_WPULSE);
    dq_oe_d  = (state_d == ST_WSETUP) || (state_d == ST_WPULSE) ||
               (state_d == ST_WHOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      ce_n        <= 1'b1;
      oe_n        <= 1'b1;
      we_n        <= 1'b1;
      dq_oe       <= 1'b0;
      rdata_valid <= 1'b0;
    end else begin
      state_q     <= state_d;
      ce_n        <= ce_n_d;
      oe_n        <= oe_n_d;
      we_n        <= we_n_d;
      dq_oe       <= dq_oe_d;
      rdata_valid <= capture;
    end
  end

  // R2: idle means deselected
  a_r2_standby_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> ce_n);

  // R6: never drive against the RAM's outputs
  a_r6_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !(dq_oe && !oe_n));

  // R5: a write strobe only inside a selected, driven cycle
  a_r5_we_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!ce_n && dq_oe));

  // R7: output enable falls only after a released, deselected cycle
  a_r7_oe_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_n) |-> ($past(ce_n) && !$past(dq_oe)));

  // R7: the bus is driven only after a cycle with output enable off
  a_r7_drive_after_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> ($past(oe_n) && $past(ce_n)));

  // R8: an accepted bus access makes the controller busy
  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_any_lane) |=> !req_ready);

  // R3: read data is returned while idle
  a_r3_valid_in_idle: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_valid |-> req_ready);

endmodule

// File: rtl/asram_lanes.sv
module asram_lanes #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int LANE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     accept,
  input  logic                     capture,
  input  logic                     access_d,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic [DATA_W/LANE_W-1:0] req_be,
  input  logic [DATA_W-1:0]        dq_in,
  output logic [ADDR_W-1:0]        sram_addr,
  output logic [DATA_W-1:0]        dq_out,
  output logic [DATA_W/LANE_W-1:0] be_n,
  output logic [DATA_W-1:0]        rdata
);

  localparam int LANES = DATA_W / LANE_W;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  be_q;
  logic [LANES-1:0]  be_next;
  logic [LANES-1:0]  be_n_d;
  logic [DATA_W-1:0] cap_d;
  logic [DATA_W-1:0] rdata_q;
  logic [LANES-1:0]  be_n_q;
  logic [DATA_W-1:0] sel_bits;

  assign be_next = accept ? req_be : be_q;
  assign be_n_d  = access_d ? ~be_next : '1;

  // Request latch: loaded only when a request is taken
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      be_q    <= req_be;
    end
  end

  // Lane steering: masking of captured data and expansion of the mask
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign cap_d[l*LANE_W +: LANE_W]    = be_next[l] ? dq_in[l*LANE_W +: LANE_W]
                                                     : '0;
    assign sel_bits[l*LANE_W +: LANE_W] = {LANE_W{be_q[l]}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (capture) rdata_q <= cap_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) be_n_q <= '1;
    else        be_n_q <= be_n_d;
  end

  assign sram_addr = addr_q;
  assign dq_out    = wdata_q;
  assign be_n      = be_n_q;
  assign rdata     = rdata_q;

  // R4: lanes outside the mask come back as zero
  a_r4_unselected_zero: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> ((rdata_q & ~sel_bits) == '0));

  // R4: strobes are released whenever no access is running
  a_r4_strobes_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !access_d |=> (be_n_q == '1));

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl #(
  parameter int ADDR_W  = 18,
  parameter int DATA_W  = 16,
  parameter int LANE_W  = 8,
  parameter int RD_WAIT = 3,
  parameter int WR_WAIT = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic [DATA_W/LANE_W-1:0] req_be,
  output logic [DATA_W-1:0]        rdata,
  output logic                     rdata_valid,
  output logic [ADDR_W-1:0]        sram_addr,
  output logic                     sram_ce_n,
  output logic                     sram_oe_n,
  output logic                     sram_we_n,
  output logic [DATA_W/LANE_W-1:0] sram_be_n,
  output logic [DATA_W-1:0]        sram_dq_out,
  output logic                     sram_dq_oe,
  input  logic [DATA_W-1:0]        sram_dq_in
);

  localparam int MAX_WAIT = (RD_WAIT > WR_WAIT) ? RD_WAIT : WR_WAIT;
  localparam int CNT_W    = $clog2(MAX_WAIT) + 1;

  logic             accept;
  logic             capture;
  logic             access_d;
  logic             timer_start;
  logic             timer_expire;
  logic [CNT_W-1:0] timer_load;
  logic             req_any_lane;

  assign req_any_lane = |req_be;

  asram_seq #(
    .CNT_W   (CNT_W),
    .RD_WAIT (RD_WAIT),
    .WR_WAIT (WR_WAIT)
  ) seq_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_any_lane (req_any_lane),
    .timer_expire (timer_expire),
    .req_ready    (req_ready),
    .accept       (accept),
    .capture      (capture),
    .timer_start  (timer_start),
    .timer_load   (timer_load),
    .access_d     (access_d),
    .ce_n         (sram_ce_n),
    .oe_n         (sram_oe_n),
    .we_n         (sram_we_n),
    .dq_oe        (sram_dq_oe),
    .rdata_valid  (rdata_valid)
  );

  asram_timer #(
    .CNT_W (CNT_W)
  ) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (timer_start),
    .load_val (timer_load),
    .expire   (timer_expire)
  );

  asram_lanes #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LANE_W (LANE_W)
  ) lanes_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .capture   (capture),
    .access_d  (access_d),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_be    (req_be),
    .dq_in     (sram_dq_in),
    .sram_addr (sram_addr),
    .dq_out    (sram_dq_out),
    .be_n      (sram_be_n),
    .rdata     (rdata)
  );

  // R5: setup margin before the write strobe falls
  a_r5_write_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_we_n) |-> ($past(!sram_ce_n) && $stable(sram_addr) &&
                          $stable(sram_be_n) && $stable(sram_dq_out)));

  // R5: hold margin after the write strobe rises
  a_r5_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (!sram_ce_n && sram_dq_oe && $stable(sram_addr) &&
                          $stable(sram_be_n) && $stable(sram_dq_out)));

  // R5 / R3: nothing on the address side moves inside an access
  a_r5_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n && $past(!sram_ce_n)) |-> ($stable(sram_addr) && $stable(sram_be_n)));

endmodule

// File: tb/asram_ctrl_tb_top.sv
module asram_ctrl_tb_top;

  localparam int RD_WAIT = 3;
  localparam int WR_WAIT = 2;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic        req_write;
  logic [17:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_be;
  logic [15:0] rdata;
  logic        rdata_valid;
  logic [17:0] sram_addr;
  logic        sram_ce_n;
  logic        sram_oe_n;
  logic        sram_we_n;
  logic [1:0]  sram_be_n;
  logic [15:0] sram_dq_out;
  logic        sram_dq_oe;
  logic [15:0] sram_dq_in;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  asram_ctrl #(
    .ADDR_W (18), .DATA_W (16), .LANE_W (8),
    .RD_WAIT (RD_WAIT), .WR_WAIT (WR_WAIT)
  ) dut_i (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
    .req_addr (req_addr), .req_wdata (req_wdata), .req_be (req_be),
    .rdata (rdata), .rdata_valid (rdata_valid),
    .sram_addr (sram_addr), .sram_ce_n (sram_ce_n), .sram_oe_n (sram_oe_n),
    .sram_we_n (sram_we_n), .sram_be_n (sram_be_n),
    .sram_dq_out (sram_dq_out), .sram_dq_oe (sram_dq_oe), .sram_dq_in (sram_dq_in)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] lane_mask(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  // ---------------- RAM model (updates on falling edges) ----------------
  logic [15:0] ram   [int];
  logic [15:0] model_dq;
  logic        prev_we;

  function automatic logic [15:0] ram_rd(input int a);
    if (ram.exists(a)) return ram[a];
    return 16'h0000;
  endfunction

  assign sram_dq_in = model_dq;

  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_we  <= 1'b1;
      model_dq <= 16'hDEAD;
    end else begin
      if (!prev_we && sram_we_n && !sram_ce_n && sram_dq_oe) begin
        logic [15:0] cur;
        cur = ram_rd(int'(sram_addr));
        if (!sram_be_n[0]) cur[7:0]  = sram_dq_out[7:0];
        if (!sram_be_n[1]) cur[15:8] = sram_dq_out[15:8];
        ram[int'(sram_addr)] = cur;
      end
      prev_we <= sram_we_n;
      if (!sram_ce_n && !sram_oe_n && sram_we_n) begin
        logic [15:0] v;
        v = ram_rd(int'(sram_addr));
        if (sram_be_n[0]) v[7:0]  = 8'hA5;
        if (sram_be_n[1]) v[15:8] = 8'h5A;
        model_dq <= v;
      end else begin
        model_dq <= 16'hDEAD;
      end
    end
  end

  // ---------------- protocol monitor ----------------
  logic        p_ce_n, p_oe_n, p_we_n, p_dq_oe;
  logic [17:0] p_addr;
  logic [1:0]  p_be_n;
  logic [15:0] p_dq;
  int          ce_run, oe_run, we_run;
  bit          was_write;

  always @(negedge clk) begin
    if (rst_n) begin
      chk(!(sram_dq_oe && !sram_oe_n), "R6 bus driven while oe low", 32'(sram_dq_oe), 0);
      chk(!req_ready || sram_ce_n, "R2 ce high when ready", 32'(sram_ce_n), 1);
      chk(sram_we_n || (!sram_ce_n && sram_dq_oe), "R5 we low qualified",
          32'({sram_ce_n, sram_dq_oe}), 32'b01);
      if (sram_dq_oe && !p_dq_oe)
        chk(p_oe_n && p_ce_n, "R7 released cycle before drive", 32'({p_ce_n, p_oe_n}), 3);
      if (!sram_oe_n && p_oe_n)
        chk(p_ce_n && !p_dq_oe, "R7 released cycle before read", 32'({p_ce_n, p_dq_oe}), 2);
      if (!sram_ce_n && !p_ce_n)
        chk(sram_addr == p_addr && sram_be_n == p_be_n && (!sram_dq_oe || sram_dq_out == p_dq),
            "R5 address/strobes/data steady", 32'(sram_addr), 32'(p_addr));
      if (!sram_we_n) begin we_run++; was_write = 1; end
      else if (!p_we_n) begin
        chk(we_run == WR_WAIT, "R5 write pulse length", 32'(we_run), 32'(WR_WAIT));
        chk(!sram_ce_n && sram_dq_oe, "R5 hold cycle after pulse", 32'(sram_ce_n), 0);
        we_run = 0;
      end
      if (!sram_oe_n) oe_run++;
      else if (!p_oe_n) begin
        chk(oe_run == RD_WAIT, "R3 read access length", 32'(oe_run), 32'(RD_WAIT));
        oe_run = 0;
      end
      if (!sram_ce_n) ce_run++;
      else if (!p_ce_n) begin
        chk(ce_run == (was_write ? WR_WAIT + 2 : RD_WAIT), "R5 chip select length",
            32'(ce_run), 32'(was_write ? WR_WAIT + 2 : RD_WAIT));
        ce_run = 0; was_write = 0;
      end
    end else begin
      ce_run = 0; oe_run = 0; we_run = 0; was_write = 0;
    end
    p_ce_n = sram_ce_n; p_oe_n = sram_oe_n; p_we_n = sram_we_n;
    p_dq_oe = sram_dq_oe; p_addr = sram_addr; p_be_n = sram_be_n; p_dq = sram_dq_out;
  end

  // ---------------- scoreboard ----------------
  logic [15:0] shadow [int];
  logic [15:0] exp_q [$];
  string       tag_q [$];

  function automatic logic [15:0] sh_rd(input int a);
    if (shadow.exists(a)) return shadow[a];
    return 16'h0000;
  endfunction

  always @(negedge clk) begin
    if (rst_n && rdata_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected read data", 32'(rdata), 0);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rdata == e, t, 32'(rdata), 32'(e));
      end
    end
  end

  task automatic issue(input bit wr, input logic [17:0] a, input logic [15:0] d,
                       input logic [1:0] be, input string tag);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    if (wr) begin
      shadow[int'(a)] = (sh_rd(int'(a)) & ~lane_mask(be)) | (d & lane_mask(be));
    end else begin
      exp_q.push_back(sh_rd(int'(a)) & lane_mask(be));
      tag_q.push_back(tag);
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_drain();
    for (int k = 0; k < 200 && (exp_q.size() != 0 || !req_ready); k++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; req_be = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sram_ce_n && sram_oe_n && sram_we_n && sram_be_n == 2'b11,
        "R1 controls high in reset", 32'({sram_ce_n, sram_oe_n, sram_we_n, sram_be_n}), 32'h1f);
    chk(!sram_dq_oe && req_ready && !rdata_valid, "R1 bus released, ready, no valid",
        32'({sram_dq_oe, req_ready, rdata_valid}), 32'b010);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 / R8 full write, ready returns after WR_WAIT+2
    issue(1, 18'h00010, 16'h1234, 2'b11, "R5 write");
    begin
      int n;
      n = 0;
      while (!req_ready && n < 50) begin n++; @(negedge clk); end
      chk(n == WR_WAIT + 2, "R8 write busy cycles", 32'(n), 32'(WR_WAIT + 2));
    end

    // R3 read latency and data
    issue(0, 18'h00010, 16'h0, 2'b11, "R3 full read");
    begin
      int n;
      n = 1;
      while (!rdata_valid && n < 50) begin @(negedge clk); n++; end
      chk(n == RD_WAIT + 1, "R3 read latency", 32'(n), 32'(RD_WAIT + 1));
      @(negedge clk);
      chk(!rdata_valid, "R3 valid is one cycle", 32'(rdata_valid), 0);
    end

    // R4 partial writes and reads on each lane
    issue(1, 18'h00010, 16'hFFCD, 2'b01, "R4 lower write");
    issue(0, 18'h00010, 16'h0, 2'b11, "R4 after lower write");
    issue(1, 18'h00010, 16'h77FF, 2'b10, "R4 upper write");
    issue(0, 18'h00010, 16'h0, 2'b10, "R4 upper-only read");
    issue(0, 18'h00010, 16'h0, 2'b01, "R4 lower-only read");
    issue(0, 18'h00010, 16'h0, 2'b11, "R4 both lanes read");

    // R5 boundary addresses
    issue(1, 18'h00000, 16'hA001, 2'b11, "R5 write addr 0");
    issue(1, 18'h3FFFF, 16'hB3FF, 2'b11, "R5 write top addr");
    issue(0, 18'h3FFFF, 16'h0, 2'b11, "R5 read top addr");
    issue(0, 18'h00000, 16'h0, 2'b11, "R5 read addr 0");
    wait_drain();

    // R9 empty-mask write: no bus activity, RAM unchanged
    issue(1, 18'h00010, 16'hFFFF, 2'b00, "R9 null write");
    chk(sram_ce_n && req_ready, "R9 null write leaves bus idle",
        32'({sram_ce_n, req_ready}), 3);
    @(negedge clk);
    chk(sram_ce_n, "R9 ce stays high", 32'(sram_ce_n), 1);
    issue(0, 18'h00010, 16'h0, 2'b11, "R9 RAM unchanged after null write");
    wait_drain();

    // R9 empty-mask read: zero data one cycle after acceptance
    issue(0, 18'h00000, 16'h0, 2'b00, "R9 null read data");
    chk(rdata_valid && sram_ce_n, "R9 null read valid next cycle",
        32'({rdata_valid, sram_ce_n}), 3);
    wait_drain();

    // R7 / R4 mixed traffic, back to back, all masks
    for (int i = 0; i < 40; i++) begin
      logic [17:0] a;
      logic [15:0] d;
      a = 18'h20 + 18'((i * 5) % 8);
      d = 16'(i * 16'h1357) ^ 16'hA5A5;
      issue((i % 3) != 2, a, d, 2'(i), "R7 mixed traffic read");
    end
    wait_drain();
    chk(exp_q.size() == 0, "R3 all reads returned", 32'(exp_q.size()), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule